// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Read Controller

This block sits on the host side of an asynchronous pseudo-SRAM that supports page-mode reads. It runs from a synchronous clock. A host request carries a start word address and a word count. The controller turns the request into a sequence of chip-enable, output-enable and address changes on the memory pins. Each word read back is returned on a one-cycle valid strobe. A single done pulse marks the end of the whole request.

The memory groups words into pages of 2^PAGE_BITS words (16 by default), selected by the low address bits. The first word of a page needs the long random-access latency. While the upper address bits stay fixed, each following word needs only the short page-access latency. When the word sequence crosses a page boundary, the controller closes the page: it raises the chip and output enables for one cycle, then opens the next page with a full-latency access. Writes have no page mode. Each write is one full-latency access of one word.

All latencies are parameters counted in clock cycles. The pin-level analog timing and the refresh of the memory are outside this block.

Top module: `psram_page_reader`

## Requirements
- R1: After reset, `req_ready`=1, `mem_ce_n`=`mem_oe_n`=`mem_we_n`=1, and `mem_dq_oe`, `rd_valid` and `done` are all 0.
- R2: A read request is accepted at the clock edge where `req_valid`=1 and `req_ready`=1. Call the cycle after that edge cycle 0. The first word arrives on `rd_valid` in cycle T_AA, with `rd_data` equal to the memory word at the start address.
- R3: Each later word in the same page (address bits [PAGE_BITS-1:0] incrementing) arrives T_APA cycles after the previous word. Its data comes from the address one higher than the previous word's.
- R4: A word whose address has bits [3:0] all ones, when it is not the last word, closes the page. `mem_ce_n`/`mem_oe_n` go high for exactly one cycle, and the next word arrives 1+T_AA cycles after it.
- R5: During a read, whenever `mem_ce_n`=0, `mem_oe_n` equals `mem_ce_n`, `mem_we_n`=1, and `mem_addr` bits above [3:0] equal those of the word being fetched.
- R6: A read returns exactly `req_len` words. `done` is high for exactly one cycle, the cycle after the last `rd_valid`.
- R7: A write request makes one access of one word, whatever `req_len` holds. `mem_ce_n`=`mem_we_n`=0 for exactly T_WR cycles (cycles 0 to T_WR-1), with `mem_oe_n`=1, `mem_dq_oe`=1 and `mem_dq_out`=`req_wdata`. `done` pulses in cycle T_WR+1.
- R8: `req_ready` is low from the accept edge until the transaction ends. A request held while busy is not taken until then. `mem_ce_n` is high for at least one cycle between two transactions.
- R9: A read request with `req_len`=0 is ignored. `req_ready` stays 1, `mem_ce_n` stays 1 and no `done` occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word write, 0 = burst read |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of words to read |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DW | Read word |
| done | output | 1 | One-cycle end-of-request pulse |
| mem_addr | output | AW | Memory word address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DW | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data from memory |

## Verification
Two events can fall in the same cycle: a read delivers its final word, and a new request is already waiting. The bench provokes this by holding a write request on `req_valid` through an entire read burst. It judges the outcome by cycle number. `req_ready` must stay low through the burst, and `mem_ce_n` must be high in the cycle of the last `rd_valid`. `mem_we_n` must first fall exactly one cycle after that last word, and the write must then land in the memory model. A burst that ends exactly on a page's last word is also run, to check that end-of-burst wins over page closing.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_GAP   = 2'd2,
      ST_WRITE = 2'd3
   } ctl_state_t;
endpackage

// File: rtl/psram_lat_timer.sv
module psram_lat_timer #(
   parameter int unsigned MAX_WAIT = 6,
   parameter int unsigned CW       = $clog2(MAX_WAIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          hit
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign hit = (cnt_q == CW'(1));

   // R3: wait counter never exceeds the longest latency
   a_r3_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAX_WAIT));
   // R2: every latency loaded is at least one cycle
   a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));
endmodule

// File: rtl/psram_word_seq.sv
module psram_word_seq #(
   parameter int unsigned AW = 20,
   parameter int unsigned LW = 8,
   parameter int unsigned PB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] start_addr,
   input  logic [LW-1:0] word_cnt,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last,
   output logic          page_end
);
   logic [LW-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         rem_q <= '0;
      end else if (load) begin
         addr  <= start_addr;
         rem_q <= word_cnt;
      end else if (step) begin
         addr  <= addr + 1'b1;
         rem_q <= rem_q - 1'b1;
      end
   end

   assign last = (rem_q == LW'(1));

   generate
      if (PB == 0) begin : g_no_page
         assign page_end = 1'b1;
      end else begin : g_page
         assign page_end = &addr[PB-1:0];
      end
   endgenerate

   // R6: no word is fetched beyond the requested count
   a_r6_step_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (rem_q != '0));
endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
   import psram_rd_pkg::*;
#(
   parameter int unsigned AW        = 20,
   parameter int unsigned DW        = 16,
   parameter int unsigned LW        = 8,
   parameter int unsigned PAGE_BITS = 4,
   parameter int unsigned T_AA      = 6,
   parameter int unsigned T_APA     = 2,
   parameter int unsigned T_WR      = T_AA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          done,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_in
);
   localparam int unsigned MAXW = (T_AA > T_WR) ? T_AA : T_WR;
   localparam int unsigned CW   = $clog2(MAXW + 1);

   if (T_APA < 1 || T_APA >= T_AA) begin : g_bad_apa
      $error("page latency must be at least 1 and below the random latency");
   end
   if (T_WR < 1) begin : g_bad_wr
      $error("write latency must be at least 1");
   end
   if (PAGE_BITS >= AW) begin : g_bad_page
      $error("page must be smaller than the address space");
   end

   ctl_state_t    state_q, state_d;
   logic          accept, hit, last, page_end;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          rd_hit, wr_hit, fin_q;
   logic [DW-1:0] wdata_q;

   assign accept = (state_q == ST_IDLE) && req_valid && (req_write || req_len != '0);
   assign rd_hit = (state_q == ST_READ)  && hit;
   assign wr_hit = (state_q == ST_WRITE) && hit;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = CW'(T_AA);
      case (state_q)
         ST_IDLE: if (accept) begin
            state_d  = req_write ? ST_WRITE : ST_READ;
            tmr_load = 1'b1;
            tmr_val  = req_write ? CW'(T_WR) : CW'(T_AA);
         end
         ST_READ: if (hit) begin
            if (last)          state_d = ST_IDLE;
            else if (page_end) state_d = ST_GAP;
            else begin
               tmr_load = 1'b1;
               tmr_val  = CW'(T_APA);
            end
         end
         ST_GAP: begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CW'(T_AA);
         end
         ST_WRITE: if (hit) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   psram_lat_timer #(.MAX_WAIT(MAXW), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .hit(hit)
   );

   psram_word_seq #(.AW(AW), .LW(LW), .PB(PAGE_BITS)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(accept), .start_addr(req_addr),
      .word_cnt(req_len), .step(rd_hit), .addr(mem_addr), .last(last),
      .page_end(page_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         fin_q    <= 1'b0;
         done     <= 1'b0;
         wdata_q  <= '0;
      end else begin
         state_q  <= state_d;
         rd_valid <= rd_hit;
         if (rd_hit) rd_data <= mem_dq_in;
         fin_q    <= (rd_hit && last) || wr_hit;
         done     <= fin_q;
         if (accept) wdata_q <= req_wdata;
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign mem_ce_n   = !((state_q == ST_READ) || (state_q == ST_WRITE));
   assign mem_oe_n   = (state_q != ST_READ);
   assign mem_we_n   = (state_q != ST_WRITE);
   assign mem_dq_oe  = (state_q == ST_WRITE);
   assign mem_dq_out = wdata_q;

   // R5: upper address fixed while a page stays open
   a_r5_page_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) == ST_READ)
         |-> $stable(mem_addr[AW-1:PAGE_BITS]));
   // R8: an access only opens from idle or after a page gap
   a_r8_open_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_GAP));
   // R6: done is a single-cycle pulse
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: never output-enable and write-enable together
   a_r7_no_oe_during_we: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe));
   // R9: zero-length read leaves the controller idle
   a_r9_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !req_write && req_len == '0) |=> req_ready);
   // R2: read words only appear after a read access
   a_r2_valid_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(state_q) == ST_READ && !$past(mem_oe_n)));
endmodule

// File: tb/tb_psram_page_reader.sv
`timescale 1ns/1ps
module tb_psram_page_reader;
   localparam int AW = 20, DW = 16, LW = 8, PB = 4;
   localparam int T_AA = 6, T_APA = 2, T_WR = 6;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rd_valid, done;
   logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

   int n_chk = 0, n_bad = 0, tick = 0;
   logic [DW-1:0] model_mem [256];
   logic [DW-1:0] exp_mem   [256];

   always #2.5 clk = ~clk;

   psram_page_reader #(.AW(AW), .DW(DW), .LW(LW), .PAGE_BITS(PB),
      .T_AA(T_AA), .T_APA(T_APA), .T_WR(T_WR)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? model_mem[mem_addr[7:0]] : 16'h0000;
   always @(posedge clk)
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr[7:0]] <= mem_dq_out;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      tick++;
      if (tick > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R6 actual=%0d expected=%0d", tick, 100000);
         summary_and_end();
      end
   end

   // burst read with full timing and data check
   task automatic do_read(input logic [AW-1:0] a, input int len);
      int k = 0, t_exp = T_AA, last_cyc = -1, done_cyc = -1, high = 0, gaps = 0;
      int pin_err = 0;
      bit after_cross = 0;
      logic [AW-1:0] cur = a;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_len = LW'(len);
      @(posedge clk);
      for (int cyc = 0; cyc < 3000; cyc++) begin
         @(negedge clk);
         if (cyc == 0) req_valid = 0;
         if (mem_ce_n) high++;
         else if (mem_oe_n != mem_ce_n || !mem_we_n || mem_addr[AW-1:PB] != cur[AW-1:PB])
            pin_err++;
         if (rd_valid) begin
            if (k == 0) chk(cyc == t_exp, "R2 first-word cycle", cyc, t_exp);
            else if (after_cross) chk(cyc == t_exp, "R4 new-page cycle", cyc, t_exp);
            else chk(cyc == t_exp, "R3 page-word cycle", cyc, t_exp);
            chk(rd_data == exp_mem[cur[7:0]], k == 0 ? "R2 data" : "R3 data", rd_data, exp_mem[cur[7:0]]);
            after_cross = (cur[PB-1:0] == '1);
            if (after_cross && k + 1 < len) gaps++;
            t_exp += after_cross ? (1 + T_AA) : T_APA;
            cur = cur + 1'b1;
            k++;
            last_cyc = cyc;
         end
         if (done) begin done_cyc = cyc; break; end
      end
      chk(k == len, "R6 word count", k, len);
      chk(done_cyc == last_cyc + 1, "R6 done cycle", done_cyc, last_cyc + 1);
      chk(high == gaps + 2, "R4 enable-high cycles", high, gaps + 2);
      chk(pin_err == 0, "R5 pins during page", pin_err, 0);
      @(negedge clk);
      chk(!done, "R6 done single pulse", done, 0);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
      int low = 0, pin_err = 0, done_cyc = -1;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_len = LW'(len); req_wdata = d;
      @(posedge clk);
      for (int cyc = 0; cyc < 100; cyc++) begin
         @(negedge clk);
         if (cyc == 0) begin req_valid = 0; req_wdata = ~d; end
         if (!mem_we_n) begin
            low++;
            if (mem_ce_n || !mem_oe_n || !mem_dq_oe || mem_dq_out != d || mem_addr != a || cyc >= T_WR)
               pin_err++;
         end
         if (done) begin done_cyc = cyc; break; end
      end
      chk(low == T_WR, "R7 write-enable cycles", low, T_WR);
      chk(pin_err == 0, "R7 write pins", pin_err, 0);
      chk(done_cyc == T_WR + 1, "R7 done cycle", done_cyc, T_WR + 1);
      exp_mem[a[7:0]] = d;
   endtask

   // {write, addr, len, wdata}
   localparam logic [44:0] VEC [9] = '{
      {1'b0, 20'h00010, 8'd4,  16'h0000},
      {1'b0, 20'h0002C, 8'd8,  16'h0000},
      {1'b1, 20'h00005, 8'd1,  16'h1234},
      {1'b0, 20'h00003, 8'd4,  16'h0000},
      {1'b0, 20'h0003F, 8'd2,  16'h0000},
      {1'b0, 20'h00040, 8'd16, 16'h0000},
      {1'b0, 20'h0007E, 8'd20, 16'h0000},
      {1'b1, 20'h00041, 8'd5,  16'hBEEF},
      {1'b0, 20'h00041, 8'd1,  16'h0000}
   };

   initial begin
      for (int i = 0; i < 256; i++) begin
         model_mem[i] = {~i[7:0], i[7:0]};
         exp_mem[i]   = {~i[7:0], i[7:0]};
      end
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && !done,
          "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, done}, 6'b111000);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && !done, "R1 after release", {req_ready, mem_ce_n, done}, 3'b110);

      for (int v = 0; v < 9; v++) begin
         if (VEC[v][44]) do_write(VEC[v][43:24], VEC[v][15:0], int'(VEC[v][23:16]));
         else            do_read(VEC[v][43:24], int'(VEC[v][23:16]));
      end

      // R9 zero-length read ignored
      begin
         int bad = 0;
         @(negedge clk);
         req_valid = 1; req_write = 0; req_addr = 20'h00020; req_len = '0;
         for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (!req_ready || !mem_ce_n || done || rd_valid) bad++;
         end
         req_valid = 0;
         chk(bad == 0, "R9 zero-length ignored", bad, 0);
      end

      // R8 request held through a busy read, then taken after the last word
      begin
         int last_cyc = -1, we_cyc = -1, rdy_bad = 0, ce_at_last = 0, done_n = 0;
         @(negedge clk);
         req_valid = 1; req_write = 0; req_addr = 20'h00010; req_len = 8'd3;
         @(posedge clk);
         #1 req_write = 1; req_addr = 20'h00020; req_wdata = 16'h7E57; req_len = 8'd1;
         for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            if (rd_valid) begin last_cyc = cyc; ce_at_last = mem_ce_n; end
            if (last_cyc < 0 && req_ready) rdy_bad++;
            if (!mem_we_n && we_cyc < 0) begin we_cyc = cyc; req_valid = 0; end
            if (done) done_n++;
            if (done_n == 2) break;
         end
         chk(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
         chk(ce_at_last == 1, "R8 enable high between transactions", ce_at_last, 1);
         chk(we_cyc == last_cyc + 1, "R8 held request start", we_cyc, last_cyc + 1);
         exp_mem[8'h20] = 16'h7E57;
      end
      do_read(20'h0001F, 3);   // R7 readback of held write, R4 cross
      do_read(20'h00000, 1);

      summary_and_end();
   end
endmodule